// File: doc/BRIEF.md
# Accumulator Add/Subtract Flag Unit

This block holds an 8-bit accumulator and an 8-bit status word and performs one command per clock: add, add with carry, subtract with borrow, load the accumulator, or load the status word. Arithmetic takes the accumulator and the data input as operands and updates the carry, auxiliary carry and overflow flags. The user flag, the two bank-select bits and the spare bit are left alone by arithmetic.

The parity bit is not stored. It is derived from the accumulator register at all times, so it follows every change: arithmetic results and plain loads alike. A status-word load cannot override it. Results appear on the outputs one clock after the command is presented.

Status word layout, with bit 7 as the most significant: 7 carry, 6 auxiliary carry, 5 user flag, 4 bank select high, 3 bank select low, 2 overflow, 1 spare, 0 parity.

Top module: `alu_flag_unit`

## Requirements
- R1: While rst_ni is low, and after reset until the first command, acc_o and psw_o are both 00h.
- R2: Command 1 (add) sets acc to (acc + data) mod 256 and carry (bit 7) to the carry out of bit 7. The incoming carry is ignored.
- R3: Command 2 (add with carry) sets acc to (acc + data + carry) mod 256, with carry taken from the sum's bit 8.
- R4: Command 3 (subtract with borrow) sets acc to (acc - data - carry) mod 256, and sets carry when the true difference is negative.
- R5: Auxiliary carry (bit 6). For commands 1 and 2 it is set when the low-nibble sum carries into bit 4, or when the low nibble of the result is 0Ah to 0Fh. For command 3 it is set when acc[3:0] is less than data[3:0] plus the carry.
- R6: Overflow (bit 2) is set after commands 1 to 3 when the signed 8-bit result of the same operation lies outside -128 to +127. Otherwise it is cleared.
- R7: Parity (bit 0) always equals the XOR of the acc_o bits, so that the ones in acc_o and the parity bit add up to an even count. A status-word load cannot change it.
- R8: Commands 1 to 3 leave status bits 5, 4, 3 and 1 unchanged. Command 5 (status load) writes data bits 7 to 1 into status bits 7 to 1 and leaves acc unchanged.
- R9: Command 4 (load) copies data into acc and leaves status bits 7 to 1 unchanged. Commands 0, 6 and 7 change neither acc nor status bits 7 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 none, 1 add, 2 add with carry, 3 subtract with borrow, 4 load acc, 5 load status, 6/7 none |
| data_i | input | 8 | Second operand or load value |
| acc_o | output | 8 | Accumulator register |
| psw_o | output | 8 | Status word, parity derived from acc_o |

## Verification
The assertions assume that cmd_i and data_i are known and settled at each rising clock edge. They also assume that a single command fully determines the next register values, with no other source writing the accumulator or the status word. The bench drives new values only on falling edges and holds them through the following rising edge. It draws commands from all eight codes, so the unused codes are covered too. Directed cases then hit the nibble-carry, signed-limit and borrow corners.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ADD  = 3'd1,
    CMD_ADDC = 3'd2,
    CMD_SUBB = 3'd3,
    CMD_LDA  = 3'd4,
    CMD_LDSW = 3'd5
  } cmd_e;

  // status bit positions
  localparam int SW_CY  = 7;
  localparam int SW_AC  = 6;
  localparam int SW_F0  = 5;
  localparam int SW_RS1 = 4;
  localparam int SW_RS0 = 3;
  localparam int SW_OV  = 2;
  localparam int SW_SP  = 1;
  localparam int SW_P   = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;
endpackage

// File: rtl/afu_adder.sv
module afu_adder #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4,
  parameter int LO_LIM = 10
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  input  logic              sub_i,
  input  logic              use_cy_i,
  output logic [DATA_W-1:0] res_o,
  output alu_flag_pkg::arith_flags_t flags_o
);
  localparam int MID_W = DATA_W - 1 - NIB_W;

  logic [DATA_W-1:0] b_x;
  logic              cin;
  logic [NIB_W-1:0]  s_lo;
  logic [MID_W-1:0]  s_mid;
  logic              s_top;
  logic              c_lo, c_mid, c_out;

  always_comb begin
    // subtraction as a + ~b + ~borrow
    b_x = sub_i ? ~b_i : b_i;
    if (sub_i)       cin = ~cy_i;
    else if (use_cy_i) cin = cy_i;
    else             cin = 1'b0;

    {c_lo, s_lo} = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};
    {c_mid, s_mid} = {1'b0, a_i[DATA_W-2:NIB_W]} + {1'b0, b_x[DATA_W-2:NIB_W]}
                   + {{MID_W{1'b0}}, c_lo};
    {c_out, s_top} = {1'b0, a_i[DATA_W-1]} + {1'b0, b_x[DATA_W-1]} + {1'b0, c_mid};

    res_o = {s_top, s_mid, s_lo};

    if (sub_i) begin
      flags_o.cy = ~c_out;
      flags_o.ac = ~c_lo;
    end else begin
      flags_o.cy = c_out;
      flags_o.ac = c_lo | (32'(s_lo) >= LO_LIM);
    end
    // carry into msb differs from carry out of msb
    flags_o.ov = c_mid ^ c_out;
  end
endmodule

// File: rtl/afu_parity.sv
module afu_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] d_i,
  output logic              p_o
);
  logic [DATA_W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_chain
    assign chain[i+1] = chain[i] ^ d_i[i];
  end
  assign p_o = chain[DATA_W];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DW = alu_flag_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] psw_o
);
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:1] sw_q, sw_d;
  logic [DW-1:0] sum;
  arith_flags_t  fl;
  logic          is_arith, is_sub, use_cy, par;

  always_comb begin
    is_arith = (cmd_i == CMD_ADD) || (cmd_i == CMD_ADDC) || (cmd_i == CMD_SUBB);
    is_sub   = (cmd_i == CMD_SUBB);
    use_cy   = (cmd_i == CMD_ADDC);
  end

  afu_adder #(.DATA_W(DW), .NIB_W(4), .LO_LIM(10)) u_add (
    .a_i      (acc_q),
    .b_i      (data_i),
    .cy_i     (sw_q[SW_CY]),
    .sub_i    (is_sub),
    .use_cy_i (use_cy),
    .res_o    (sum),
    .flags_o  (fl)
  );

  always_comb begin
    acc_d = acc_q;
    sw_d  = sw_q;
    if (is_arith) begin
      acc_d         = sum;
      sw_d[SW_CY]   = fl.cy;
      sw_d[SW_AC]   = fl.ac;
      sw_d[SW_OV]   = fl.ov;
    end else if (cmd_i == CMD_LDA) begin
      acc_d = data_i;
    end else if (cmd_i == CMD_LDSW) begin
      sw_d = data_i[DW-1:1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sw_q  <= '0;
    end else begin
      acc_q <= acc_d;
      sw_q  <= sw_d;
    end
  end

  afu_parity #(.DATA_W(DW)) u_par (.d_i(acc_q), .p_o(par));

  assign acc_o = acc_q;
  assign psw_o = {sw_q, par};
endmodule

// File: rtl/afu_checker.sv
module afu_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_i,
  input logic [7:0] data_i,
  input logic [7:0] acc_o,
  input logic [7:0] psw_o
);
  assert_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_o[0] == ($countones(acc_o) % 2 == 1));

  assert_add_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1) |=> ({psw_o[7], acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(data_i)})));

  assert_subb_res_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3) |=> (acc_o == 8'($past(acc_o) - $past(data_i) - {7'd0, $past(psw_o[7])})));

  assert_keep_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 || cmd_i == 3'd2 || cmd_i == 3'd3) |=>
      ({psw_o[5:3], psw_o[1]} == $past({psw_o[5:3], psw_o[1]})));

  assert_load_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4) |=> (acc_o == $past(data_i) && psw_o[7:1] == $past(psw_o[7:1])));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0 || cmd_i == 3'd6 || cmd_i == 3'd7) |=> ($stable(acc_o) && $stable(psw_o)));
endmodule

bind alu_flag_unit afu_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_i  (cmd_i),
  .data_i (data_i),
  .acc_o  (acc_o),
  .psw_o  (psw_o)
);

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [7:0] data_i = 8'd0;
  logic [7:0] acc_o, psw_o;

  int total = 0;
  int bad = 0;
  logic [7:0] m_acc = 8'd0;
  logic [7:1] m_sw = 7'd0;

  always #2 clk_i = ~clk_i;

  alu_flag_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i),
    .data_i(data_i), .acc_o(acc_o), .psw_o(psw_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return (n % 2) == 1;
  endfunction

  // returns {cy, ac, ov, res}
  function automatic logic [10:0] model(input int op, input int a, input int b, input int c);
    int s, sa, sb, r;
    logic cy, ac, ov;
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    if (op == 3) begin
      s  = a - b - c;
      cy = s < 0;
      ac = (a % 16) < (b % 16) + c;
      r  = sa - sb - c;
    end else begin
      if (op == 1) c = 0;
      s  = a + b + c;
      cy = s > 255;
      ac = ((a % 16) + (b % 16) + c > 15) || (((s % 16) + 16) % 16 >= 10);
      r  = sa + sb + c;
    end
    ov = (r > 127) || (r < -128);
    return {cy, ac, ov, 8'(s)};
  endfunction

  task automatic step(input int op, input logic [7:0] d);
    logic [10:0] m;
    string t;
    @(negedge clk_i);
    cmd_i  = 3'(op);
    data_i = d;
    case (op)
      1, 2, 3: begin
        m = model(op, int'(m_acc), int'(d), int'(m_sw[7]));
        m_acc = m[7:0];
        m_sw[7] = m[10]; m_sw[6] = m[9]; m_sw[2] = m[8];
      end
      4: m_acc = d;
      5: m_sw = d[7:1];
      default: ;
    endcase
    @(posedge clk_i);
    #1;
    t = (op == 1) ? "R2" : (op == 2) ? "R3" : (op == 3) ? "R4" : (op == 5) ? "R8" : "R9";
    chk({t, " acc"}, acc_o, m_acc);
    chk({t, " carry"}, 8'(psw_o[7]), 8'(m_sw[7]));
    chk((op >= 1 && op <= 3) ? "R5 aux" : {t, " aux"}, 8'(psw_o[6]), 8'(m_sw[6]));
    chk((op >= 1 && op <= 3) ? "R6 ovf" : {t, " ovf"}, 8'(psw_o[2]), 8'(m_sw[2]));
    chk("R8 user/bank/spare", {4'd0, psw_o[5:3], psw_o[1]}, {4'd0, m_sw[5:3], m_sw[1]});
    chk("R7 parity", 8'(psw_o[0]), 8'(par_of(m_acc)));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    #9;
    chk("R1 acc in reset", acc_o, 8'h00);
    chk("R1 psw in reset", psw_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 acc after reset", acc_o, 8'h00);
    chk("R1 psw after reset", psw_o, 8'h00);

    // directed corners
    step(4, 8'hF1); step(1, 8'h0F);           // R2: 00, carry, aux
    chk("R2 F1+0F acc", acc_o, 8'h00);
    chk("R2 F1+0F psw", psw_o, 8'hC0);
    step(4, 8'h08); step(1, 8'h02);           // R5: 0A sets aux
    chk("R5 08+02 aux", 8'(psw_o[6]), 8'd1);
    step(4, 8'h2C);                            // R7 parity of 00101100
    chk("R7 2C parity", 8'(psw_o[0]), 8'd1);
    step(5, 8'hFF);                            // R7 status load cannot set parity on 2C? P stays 1
    step(4, 8'h03);
    chk("R7 03 parity after load", 8'(psw_o[0]), 8'd0);
    step(5, 8'h39);                            // R8 bank+user, parity bit ignored
    chk("R8 status load", psw_o, 8'h38);
    step(4, 8'h7F); step(1, 8'h01);           // R6 positive overflow
    chk("R6 7F+01 ovf", 8'(psw_o[2]), 8'd1);
    step(2, 8'h00);                            // R3 carry clear
    step(4, 8'h80); step(1, 8'h80);           // carry set
    step(2, 8'h10);                            // R3 adds carry
    chk("R3 00+10+1", acc_o, 8'h11);
    step(4, 8'h00); step(3, 8'h01);           // R4 borrow
    chk("R4 00-01 acc", acc_o, 8'hFF);
    chk("R4 00-01 carry", 8'(psw_o[7]), 8'd1);
    step(4, 8'h80); step(3, 8'h00);           // R6 80-0-1 overflow
    chk("R6 80-01 ovf", 8'(psw_o[2]), 8'd1);
    step(6, 8'h55); step(7, 8'hAA); step(0, 8'h12);

    for (int k = 0; k < 600; k++) begin
      step(int'($urandom % 8), 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule